// File: doc/BRIEF.md
# Column-Order Long-Integer Multiplier

This block multiplies two unsigned multi-digit integers whose 16-bit digits sit in two external digit memories. It produces the double-length product one digit at a time, lowest digit first. For each output column `k` a sequencer walks through every digit pair `(i, j)` with `i + j = k` that lies inside both operands. Each pair's 32-bit product is added into a 50-bit accumulator, one product per clock. At the end of a column the accumulator's low digit is written to the product memory, and the accumulator then drops that digit by shifting right. The carry that remains after the final column becomes the top product digit, so all `la + lb` digits are written, each exactly once.

The two operand read ports are combinational: the memory returns `a_rdata`/`b_rdata` in the same cycle that `a_addr`/`b_addr` are presented. A run starts with a one-cycle `start` while the unit is idle. The unit then samples `len_a` and `len_b`, which may each be 1 to 64 digits. When the run ends it gives a one-cycle `done` pulse.

The controller has five states. The unit waits in `ST_IDLE`. `ST_MAC` accumulates one digit product per cycle. `ST_EMIT` writes the column digit and shifts the accumulator. `ST_LAST` writes the top digit. `ST_FIN` raises `done`. The transitions are as follows. IDLE goes to MAC on `start`. MAC goes to EMIT when the pair index reaches the column's upper bound, and otherwise stays in MAC. EMIT goes to MAC for the next column, or to LAST after column `la+lb-2`. LAST always goes to FIN, and FIN always goes back to IDLE.

Top module: `colmul_top`

## Requirements
- R1: Digits are 16 bits wide. Operand lengths of 1 to 64 digits are taken from `len_a`/`len_b` in the cycle that `start` is accepted.
- R2: For every column `k` from 0 to `la+lb-2`, the digit written at product address `k` is the low 16 bits of the column sum of all `a[i]*b[j]` with `i+j=k`, plus the carry from the lower columns.
- R3: Product digits are written in ascending address order, from 0 to `la+lb-1`, with exactly one write per address and `la+lb` writes per run.
- R4: The top product digit, at address `la+lb-1`, is the accumulator contents left over after column `la+lb-2`.
- R5: The 50-bit accumulator never sets its top bit. Products of all-ones 64-digit operands come out exact.
- R6: While accumulating, the unit presents `a_addr < la` and `b_addr < lb`. A 1-digit by 64-digit product and a 64-digit by 1-digit product are both exact.
- R7: `done` is high for exactly one cycle, and that cycle comes directly after the write of the top product digit.
- R8: A `start` pulse or a change of `len_a`/`len_b` during a run has no effect on that run's output.
- R9: After reset, `done` and `p_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| len_a | input | 7 | Digit count of operand a (1..64) |
| len_b | input | 7 | Digit count of operand b (1..64) |
| a_addr | output | 6 | Digit index into operand a memory |
| a_rdata | input | 16 | Operand a digit at `a_addr` (same cycle) |
| b_addr | output | 6 | Digit index into operand b memory |
| b_rdata | input | 16 | Operand b digit at `b_addr` (same cycle) |
| p_we | output | 1 | Product digit write enable |
| p_addr | output | 7 | Product digit index |
| p_wdata | output | 16 | Product digit value |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong pair bound or a wrong column counter shows up at the next product write. That column's digit, or its address, then disagrees with the reference product, and every later digit usually does too, because the carry propagates upward. A wrong accumulator shift or a lost carry also appears as a bad digit, at the first column affected. A fault in the FSM's final steps shows up either as a missing or misplaced top-digit write or as `done` arriving in the wrong cycle, and this is visible within one or two cycles of the end of the run.

// File: rtl/colmul_pkg.sv
package colmul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MAC  = 3'd1,
        ST_EMIT = 3'd2,
        ST_LAST = 3'd3,
        ST_FIN  = 3'd4
    } mul_state_e;

endpackage

// File: rtl/colmul_bounds.sv
// Computes one bound of the pair index j inside column col.
// LOW_BOUND=1 : smallest j such that col-j < la   -> max(0, col+1-la)
// LOW_BOUND=0 : largest  j such that j < lb, j<=col -> min(col, lb-1)
module colmul_bounds #(
    parameter int MAX_LEN   = 64,
    parameter bit LOW_BOUND = 1'b1,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int AW    = $clog2(MAX_LEN),
    localparam int CW    = $clog2(2 * MAX_LEN)
) (
    input  logic [CW-1:0]    col,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    bound
);

    localparam int XW = CW + 1;

    generate
        if (LOW_BOUND) begin : g_low
            logic [XW-1:0] col_p1;
            logic [XW-1:0] len_x;
            logic [XW-1:0] diff;
            always_comb begin
                col_p1 = XW'(col) + XW'(1);
                len_x  = XW'(len);
                diff   = col_p1 - len_x;
                bound  = (col_p1 > len_x) ? AW'(diff) : '0;
            end
        end else begin : g_high
            logic [XW-1:0] col_x;
            logic [XW-1:0] len_x;
            logic [XW-1:0] len_m1;
            always_comb begin
                col_x  = XW'(col);
                len_x  = XW'(len);
                len_m1 = len_x - XW'(1);
                bound  = (col_x < len_x) ? AW'(col_x) : AW'(len_m1);
            end
        end
    endgenerate

endmodule

// File: rtl/colmul_acc.sv
// Wide column accumulator: clear, add one digit product, or drop the low digit.
module colmul_acc #(
    parameter int DIGIT_W = 16,
    parameter int ACC_W   = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               mac_en,
    input  logic               shift_en,
    input  logic [DIGIT_W-1:0] a_dig,
    input  logic [DIGIT_W-1:0] b_dig,
    output logic [DIGIT_W-1:0] low_dig
);

    localparam int PROD_W = 2 * DIGIT_W;

    logic [ACC_W-1:0]  acc_q;
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(a_dig) * PROD_W'(b_dig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (mac_en) begin
            acc_q <= acc_q + ACC_W'(prod);
        end else if (shift_en) begin
            acc_q <= acc_q >> DIGIT_W;
        end
    end

    assign low_dig = acc_q[DIGIT_W-1:0];

    // R5
    acc_headroom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q[ACC_W-1]);

endmodule

// File: rtl/colmul_top.sv
module colmul_top
    import colmul_pkg::*;
#(
    parameter int DIGIT_W = 16,
    parameter int MAX_LEN = 64,
    parameter int ACC_W   = 50,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int AW    = $clog2(MAX_LEN),
    localparam int CW    = $clog2(2 * MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   len_a,
    input  logic [LEN_W-1:0]   len_b,
    output logic [AW-1:0]      a_addr,
    input  logic [DIGIT_W-1:0] a_rdata,
    output logic [AW-1:0]      b_addr,
    input  logic [DIGIT_W-1:0] b_rdata,
    output logic               p_we,
    output logic [CW-1:0]      p_addr,
    output logic [DIGIT_W-1:0] p_wdata,
    output logic               done
);

    mul_state_e state_q, state_d;

    logic [LEN_W-1:0]   la_q, lb_q;
    logic [CW-1:0]      col_q;
    logic [CW-1:0]      col_nxt;
    logic [CW-1:0]      last_col;
    logic [AW-1:0]      j_q;
    logic [AW-1:0]      j_lo_nxt;
    logic [AW-1:0]      j_hi_cur;
    logic [DIGIT_W-1:0] acc_low;
    logic               acc_clr, acc_mac, acc_shift;
    logic               col_end, run_end;

    assign col_nxt  = col_q + CW'(1);
    assign last_col = CW'(la_q) + CW'(lb_q) - CW'(2);
    assign col_end  = (j_q == j_hi_cur);
    assign run_end  = (col_q == last_col);

    colmul_bounds #(.MAX_LEN(MAX_LEN), .LOW_BOUND(1'b1)) u_lo (
        .col   (col_nxt),
        .len   (la_q),
        .bound (j_lo_nxt)
    );

    colmul_bounds #(.MAX_LEN(MAX_LEN), .LOW_BOUND(1'b0)) u_hi (
        .col   (col_q),
        .len   (lb_q),
        .bound (j_hi_cur)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_MAC;
            ST_MAC:  if (col_end) state_d = ST_EMIT;
            ST_EMIT: state_d = run_end ? ST_LAST : ST_MAC;
            ST_LAST: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // column and pair sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            la_q  <= LEN_W'(1);
            lb_q  <= LEN_W'(1);
            col_q <= '0;
            j_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    la_q  <= len_a;
                    lb_q  <= len_b;
                    col_q <= '0;
                    j_q   <= '0;
                end
                ST_MAC:  if (!col_end) j_q <= j_q + AW'(1);
                ST_EMIT: if (!run_end) begin
                    col_q <= col_nxt;
                    j_q   <= j_lo_nxt;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc_clr   = 1'b0;
        acc_mac   = 1'b0;
        acc_shift = 1'b0;
        p_we      = 1'b0;
        p_addr    = col_q;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: acc_clr = start;
            ST_MAC:  acc_mac = 1'b1;
            ST_EMIT: begin
                p_we      = 1'b1;
                acc_shift = 1'b1;
            end
            ST_LAST: begin
                p_we   = 1'b1;
                p_addr = col_nxt;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    assign a_addr  = AW'(col_q - CW'(j_q));
    assign b_addr  = j_q;
    assign p_wdata = acc_low;

    colmul_acc #(.DIGIT_W(DIGIT_W), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .mac_en   (acc_mac),
        .shift_en (acc_shift),
        .a_dig    (a_rdata),
        .b_dig    (b_rdata),
        .low_dig  (acc_low)
    );

    // R6
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAC) |-> ((LEN_W'(a_addr) < la_q) && (LEN_W'(b_addr) < lb_q)));

    // R7
    done_after_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && p_addr == CW'(CW'(la_q) + CW'(lb_q) - CW'(1))) |=> done);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(la_q) && $stable(lb_q)));

endmodule

// File: tb/colmul_top_tb_top.sv
module colmul_top_tb_top;

    typedef struct packed {
        logic [6:0]  addr;
        logic [15:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  len_a = 7'd1, len_b = 7'd1;
    logic [5:0]  a_addr, b_addr;
    logic [15:0] a_rdata, b_rdata;
    logic        p_we;
    logic [6:0]  p_addr;
    logic [15:0] p_wdata;
    logic        done;

    logic [15:0] mem_a [64];
    logic [15:0] mem_b [64];

    exp_t  exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R2";
    int    cur_top = 1;
    bit    prev_top = 1'b0;
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    assign a_rdata = mem_a[a_addr];
    assign b_rdata = mem_b[b_addr];

    colmul_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .len_a(len_a), .len_b(len_b),
        .a_addr(a_addr), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_rdata(b_rdata),
        .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected digits as the design writes them
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) check(prev_top, "R7 done timing", 0, 1);
            prev_top = p_we && (int'(p_addr) == cur_top);
            if (p_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 extra write", longint'(p_addr), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(p_addr == e.addr, "R3 write address", longint'(p_addr), longint'(e.addr));
                    check(p_wdata == e.data,
                          (int'(e.addr) == cur_top) ? "R4 top digit" : cur_tag,
                          longint'(p_wdata), longint'(e.data));
                end
            end
        end
    end

    // driver: loads operands, pushes the reference product, runs the unit
    task automatic run_case(input int la, input int lb, input int mode, input string tag);
        int ref_p [128];
        for (int i = 0; i < 64; i++) begin
            mem_a[i] = (mode == 1) ? 16'hFFFF : 16'($urandom);
            mem_b[i] = (mode == 1) ? 16'hFFFF : 16'($urandom);
        end
        for (int i = 0; i < 128; i++) ref_p[i] = 0;
        for (int i = 0; i < la; i++) begin
            longint unsigned carry = 0;
            for (int j = 0; j < lb; j++) begin
                longint unsigned t;
                t = longint'(unsigned'(ref_p[i+j])) + longint'(mem_a[i]) * longint'(mem_b[j]) + carry;
                ref_p[i+j] = int'(t & 64'hFFFF);
                carry = t >> 16;
            end
            ref_p[i+lb] = int'(carry);
        end
        cur_tag = tag;
        cur_top = la + lb - 1;
        for (int k = 0; k < la + lb; k++) begin
            exp_t e;
            e.addr = 7'(k);
            e.data = 16'(ref_p[k]);
            exp_q.push_back(e);
        end
        @(negedge clk);
        len_a = 7'(la);
        len_b = 7'(lb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mode == 2) begin
            // R8: disturb lengths and pulse start mid-run
            repeat (7) @(negedge clk);
            len_a = 7'd1;
            len_b = 7'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R3 write count", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9
        check(done == 1'b0 && p_we == 1'b0, "R9 reset outputs", {done, p_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_case(1, 1, 0, "R1 min length");
        run_case(64, 64, 0, "R1 max length");
        run_case(64, 64, 1, "R5 all ones");
        run_case(1, 64, 0, "R6 short a");
        run_case(64, 1, 0, "R6 short b");
        run_case(5, 9, 1, "R5 all ones mixed");
        for (int n = 0; n < 8; n++)
            run_case(1 + int'($urandom % 64), 1 + int'($urandom % 64), 0, "R2 random");
        run_case(12, 7, 2, "R8 start while busy");
        run_case(3, 3, 0, "R2 after disturb");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule